// File: doc/BRIEF.md
# Sparse Match Score Accumulator with Best-Document Selection

This block sits after a key-intersection stage in a sparse vector matcher. The upstream stage walks a query vector and a candidate document vector in key order. For every key present in both vectors, it sends one match record carrying the query weight and the candidate weight. When the candidate document ends, it sends an end marker carrying that document's identifier.

For each match record, the block multiplies the two weights and adds the product to a running score for the document being processed. On an end marker, the finished score is compared against the best score held so far. The identifier and score of the stronger document are kept, and the running score starts again from zero for the next document. A flush request presents the best identifier and score on a one-cycle result strobe and then empties the best-document store.

Normalisation and division are left to downstream logic. The block delivers only the raw correlation sum of the winning document.

Top module: `sap_doc_scorer`

## Requirements
- R1: After reset, `res_valid` is 0. A flush issued before any end marker returns `res_found`=0, `res_id`=0 and `res_score`=0.
- R2: An input cycle with `in_valid`=1 and `in_last`=0 is a match record. It adds the 24-bit product `in_qval*in_cval` to the running score of the current document.
- R3: An input cycle with `in_valid`=1 and `in_last`=1 is an end marker for document `in_doc`. Its score is the sum of the products of all match records since the previous end marker. The weight inputs are ignored on that cycle.
- R4: The running score is cleared when the end marker is taken. Products from one document never count toward the next document.
- R5: A finished score replaces the stored best only if it is strictly greater than the stored best. On a tie, the earlier document is kept.
- R6: A document with no match records scores 0. It becomes the best only when no document has been stored since reset or since the last flush.
- R7: When `flush`=1, on the next cycle `res_valid`=1 for exactly one cycle. In that cycle the outputs carry the best identifier and score, with `res_found`=1 if any document was stored. The store is then empty.
- R8: An end marker and a flush in the same cycle fold that document into the selection first. The reported result includes it.
- R9: The score is 36 bits wide. 2048 match records of weight 4095 by 4095 in one document accumulate without wrap.
- R10: Cycles with `in_valid`=0 change neither the running score nor the stored best.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input record present |
| in_last | input | 1 | 1 = end marker, 0 = match record |
| in_qval | input | 12 | Query weight of a match |
| in_cval | input | 12 | Candidate weight of a match |
| in_doc | input | 16 | Document identifier on an end marker |
| flush | input | 1 | Report best and empty the store |
| res_valid | output | 1 | One-cycle result strobe |
| res_found | output | 1 | At least one document was stored |
| res_id | output | 16 | Best document identifier |
| res_score | output | 36 | Best document score |

## Verification
The hardest states to reach are those at the edges of the best-document store. These include a tie against the stored best, an empty document arriving while the store is empty versus after a stored zero-score document, and an end marker coinciding with a flush. The stimulus sequences these deliberately rather than waiting for random traffic to hit them. The full-width accumulation case is covered by a 2048-record document at maximum weights. A behavioural model tracks the running sum and best selection with wide integers and checks every output on every cycle.

// File: rtl/sap_pkg.sv
package sap_pkg;
    localparam int VAL_W     = 12;
    localparam int ID_W      = 16;
    localparam int MAX_MATCH = 2048;
    localparam int PROD_W    = 2 * VAL_W;
    localparam int ACC_W     = PROD_W + $clog2(MAX_MATCH) + 1;

    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_MATCH = 2'd1,
        EV_END   = 2'd2
    } ev_kind_e;

    typedef struct packed {
        logic             found;
        logic [ID_W-1:0]  id;
        logic [ACC_W-1:0] score;
    } best_t;

    function automatic ev_kind_e classify(input logic valid, input logic last);
        if (!valid)     return EV_IDLE;
        else if (last)  return EV_END;
        else            return EV_MATCH;
    endfunction

    function automatic logic beats(input best_t cur, input logic [ACC_W-1:0] cand);
        return !cur.found || (cand > cur.score);
    endfunction
endpackage

// File: rtl/sap_product.sv
module sap_product
    import sap_pkg::*;
#(
    parameter int W = VAL_W
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    always_comb p = a * b;
endmodule

// File: rtl/sap_score_acc.sv
module sap_score_acc
    import sap_pkg::*;
#(
    parameter int PW = PROD_W,
    parameter int AW = ACC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  ev_kind_e      kind,
    input  logic [PW-1:0] prod,
    output logic [AW-1:0] total
);
    localparam int PAD = AW - PW;
    logic [AW-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst)                  acc_q <= '0;
        else if (kind == EV_END)  acc_q <= '0;
        else if (kind == EV_MATCH) acc_q <= acc_q + {{PAD{1'b0}}, prod};
    end

    always_comb total = acc_q;

    // R9
    acc_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == EV_MATCH) |=> (acc_q >= $past(acc_q)));

    // R4
    acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == EV_END) |=> (acc_q == '0));

    // R10
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == EV_IDLE) |=> $stable(acc_q));
endmodule

// File: rtl/sap_best_keep.sv
module sap_best_keep
    import sap_pkg::*;
#(
    parameter int IW = ID_W,
    parameter int AW = ACC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  ev_kind_e      kind,
    input  logic [IW-1:0] doc,
    input  logic [AW-1:0] total,
    input  logic          flush,
    output best_t         result,
    output logic          result_valid
);
    best_t best_q, best_nx;

    always_comb begin
        best_nx = best_q;
        if (kind == EV_END && beats(best_q, total)) begin
            best_nx.found = 1'b1;
            best_nx.id    = doc;
            best_nx.score = total;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            best_q       <= '0;
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= flush;
            if (flush) begin
                result <= best_nx;
                best_q <= '0;
            end else begin
                result <= '0;
                best_q <= best_nx;
            end
        end
    end

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !best_q.found);

    // R7
    strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> $past(flush));

    // R5
    tie_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == EV_END && best_q.found && total == best_q.score && !flush)
        |=> $stable(best_q));

    // R5
    best_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (best_q.found && !flush) |=> (best_q.score >= $past(best_q.score)));
endmodule

// File: rtl/sap_doc_scorer.sv
module sap_doc_scorer
    import sap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [VAL_W-1:0]  in_qval,
    input  logic [VAL_W-1:0]  in_cval,
    input  logic [ID_W-1:0]   in_doc,
    input  logic              flush,
    output logic              res_valid,
    output logic              res_found,
    output logic [ID_W-1:0]   res_id,
    output logic [ACC_W-1:0]  res_score
);
    ev_kind_e            kind;
    logic [PROD_W-1:0]   prod;
    logic [ACC_W-1:0]    total;
    best_t               result;

    always_comb kind = classify(in_valid, in_last);

    sap_product #(.W(VAL_W)) u_mul (
        .a(in_qval), .b(in_cval), .p(prod)
    );

    sap_score_acc #(.PW(PROD_W), .AW(ACC_W)) u_acc (
        .clk(clk), .rst(rst), .kind(kind), .prod(prod), .total(total)
    );

    sap_best_keep #(.IW(ID_W), .AW(ACC_W)) u_best (
        .clk(clk), .rst(rst), .kind(kind), .doc(in_doc), .total(total),
        .flush(flush), .result(result), .result_valid(res_valid)
    );

    always_comb begin
        res_found = result.found;
        res_id    = result.id;
        res_score = result.score;
    end

    // R1
    idle_result_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_found && res_score == '0));
endmodule

// File: tb/sap_doc_scorer_test.sv
module sap_doc_scorer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_last = 1'b0, flush = 1'b0;
    logic [11:0] in_qval = '0, in_cval = '0;
    logic [15:0] in_doc = '0;
    logic        res_valid, res_found;
    logic [15:0] res_id;
    logic [35:0] res_score;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    longint m_acc = 0;
    bit     m_have = 0;
    int     m_id = 0;
    longint m_best = 0;
    bit     e_valid = 0, e_found = 0;
    int     e_id = 0;
    longint e_score = 0;

    always #2.5 clk = ~clk;

    sap_doc_scorer uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
        .in_qval(in_qval), .in_cval(in_cval), .in_doc(in_doc), .flush(flush),
        .res_valid(res_valid), .res_found(res_found), .res_id(res_id),
        .res_score(res_score)
    );

    task automatic compare(input string tag);
        n_chk++;
        if (res_valid !== e_valid || res_found !== e_found ||
            {16'd0, res_id} !== 32'(e_id) || {28'd0, res_score} !== 64'(e_score)) begin
            n_bad++;
            $display("FAIL %s: got v=%0b f=%0b id=%0d s=%0d exp v=%0b f=%0b id=%0d s=%0d",
                     tag, res_valid, res_found, res_id, res_score,
                     e_valid, e_found, e_id, e_score);
        end
    endtask

    task automatic step(input bit v, input bit last, input int q, input int c,
                        input int id, input bit fl, input string tag);
        in_valid = v; in_last = last; in_qval = 12'(q); in_cval = 12'(c);
        in_doc = 16'(id); flush = fl;
        if (v && !last) m_acc += longint'(q) * longint'(c);
        if (v && last) begin
            if (!m_have || m_acc > m_best) begin
                m_have = 1; m_id = id; m_best = m_acc;
            end
            m_acc = 0;
        end
        if (fl) begin
            e_valid = 1; e_found = m_have;
            e_id = m_have ? m_id : 0; e_score = m_have ? m_best : 0;
            m_have = 0; m_id = 0; m_best = 0;
        end else begin
            e_valid = 0; e_found = 0; e_id = 0; e_score = 0;
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic match(input int q, input int c, input string tag);
        step(1, 0, q, c, 0, 0, tag);
    endtask
    task automatic fin(input int id, input string tag);
        step(1, 1, 12'hABC, 12'hDEF, id, 0, tag);   // weights ignored, R3
    endtask
    task automatic idle(input string tag);
        step(0, 0, 4095, 4095, 77, 0, tag);
    endtask
    task automatic flush_now(input string tag);
        step(0, 0, 0, 0, 0, 1, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare("R1 reset state");
        flush_now("R1 empty flush");
        idle("R1 after empty flush");

        // simple document, R2/R3
        match(3, 4, "R2 match");
        match(10, 10, "R2 match");
        idle("R10 idle between matches");
        fin(5, "R3 end doc5");
        flush_now("R2 R3 report doc5 score 112");
        idle("R7 strobe one cycle");

        // R4: next doc after end starts fresh, R5 greater replaces
        match(2, 2, "R4");
        fin(1, "R4 end doc1");
        match(1, 1, "R4");
        fin(2, "R4 end doc2 score 1");
        match(3, 3, "R5");
        fin(3, "R5 end doc3 score 9");
        match(9, 1, "R5");
        fin(4, "R5 tie doc4 score 9");
        flush_now("R5 tie keeps doc3");

        // R6: empty doc into empty store, then empty doc after zero doc
        fin(20, "R6 empty doc20");
        fin(21, "R6 empty doc21 tie");
        flush_now("R6 doc20 kept score 0");
        match(1, 0, "R6 zero product");
        fin(30, "R6 doc30");
        match(5, 5, "R6");
        fin(31, "R6 doc31 beats");
        fin(32, "R6 empty doc32 no replace");
        flush_now("R6 doc31 reported");

        // R8: end marker together with flush
        match(7, 7, "R8");
        fin(40, "R8 doc40");
        match(8, 8, "R8");
        step(1, 1, 0, 0, 41, 1, "R8 end+flush doc41");
        flush_now("R8 store empty afterwards");

        // R10: idle cycles with junk on weights
        match(6, 6, "R10");
        repeat (5) idle("R10 idle hold");
        fin(50, "R10 doc50 score 36");
        repeat (3) idle("R10 idle hold best");
        flush_now("R10 report 36");

        // R9: max-weight full-size document
        for (int i = 0; i < 2048; i++) match(4095, 4095, "R9 max match");
        fin(60, "R9 doc60");
        flush_now("R9 wide score");

        // random traffic
        for (int d = 0; d < 200; d++) begin
            int n;
            n = int'($urandom_range(0, 12));
            for (int k = 0; k < n; k++) begin
                if ($urandom_range(0, 3) == 0) idle("R10 rand idle");
                match(int'($urandom_range(0, 4095)), int'($urandom_range(0, 4095)),
                      "R2 rand match");
            end
            if ($urandom_range(0, 9) == 0)
                step(1, 1, 0, 0, 100 + d, 1, "R8 rand end+flush");
            else
                fin(100 + d, "R5 rand end");
            if ($urandom_range(0, 7) == 0) flush_now("R7 rand flush");
        end
        flush_now("R7 final flush");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule